// File: doc/BRIEF.md
# Clocked Input Deglitch Filter

This block cleans up an external digital input that has already passed through a hysteresis input pad. The pad removes slow-edge chatter but lets short noise spikes through. The block brings the raw level into the system clock domain with a small synchronizer. It then shifts the synchronized samples through a clocked window of flip-flops. A two-state machine moves its registered output to a new level only when every sample in the window shows that level. When the samples disagree, the output keeps its previous value. Spikes shorter than the window are therefore removed in both directions: a high spike on a low line and a low spike on a high line.

The filter works only while the system clock runs. A clock-valid status input is passed through to a `filter_inactive_o` flag, so that surrounding logic knows when the filtered level cannot be trusted. The machine has two states. `ST_LOW` takes transition `T_RISE` to `ST_HIGH` when the whole window is high. `ST_HIGH` takes transition `T_FALL` to `ST_LOW` when the whole window is low. In either state, transition `T_HOLD` keeps the state when the window is mixed or already matches the current level.

Top module: `dgl_top`

## Requirements
- R1: While `rst_ni` is low, `level_o` is 0. After reset is released, the synchronizer, the window and the machine all start from logic 0, so the output stays 0 until a high level qualifies.
- R2: With `level_o` at 0, a high pulse on `pin_i` that lasts fewer than WINDOW (default 4) consecutive sampling edges never makes `level_o` go to 1.
- R3: With `level_o` at 1, a low pulse on `pin_i` that lasts fewer than WINDOW consecutive sampling edges never makes `level_o` go to 0.
- R4: Suppose `pin_i` holds a new level for at least WINDOW consecutive sampling edges, and the first of those edges is edge k. Then `level_o` takes that level right after edge k + SYNC_STAGES + WINDOW (edge k+6 with the defaults), which is a latency of 7 edges counting edge k.
- R5: When the window holds a mix of 0 and 1 samples, `level_o` keeps its previous value. An input toggling every cycle leaves the output unchanged.
- R6: `filter_inactive_o` is 1 whenever `clk_ok_i` is 0 and is 0 whenever `clk_ok_i` is 1. It follows combinationally and has no effect on `level_o`.
- R7: Asserting `rst_ni` low while `level_o` is 1 forces `level_o` to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Raw level from the hysteresis pad |
| clk_ok_i | input | 1 | 1 when the system clock is known to be running |
| level_o | output | 1 | Filtered, registered level |
| filter_inactive_o | output | 1 | 1 while filtering is suspended (clock not valid) |

## Verification
A stuck or wrongly cleared window stage shows up at `level_o` in two ways. Either a qualified level never arrives, or it arrives one or more edges early or late against the fixed 7-edge latency. Since every edge is compared, the error is seen within the latency window after the first qualifying level. A wrong next-state decision shows up as a short pulse leaking through, or as a hold that fails during toggling, on the very edge after the window holds the offending pattern. Pulses of one, two and three cycles are driven in both polarities, together with a pulse of exactly the window length, so that an off-by-one in window depth is exposed.

// File: rtl/dgl_pkg.sv
package dgl_pkg;

    // Filter machine states; the encoding equals the filtered level.
    typedef enum logic {
        ST_LOW  = 1'b0,
        ST_HIGH = 1'b1
    } dgl_state_e;

endpackage

// File: rtl/dgl_sync.sv
module dgl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] ff_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) ff_q <= '0;
                else         ff_q <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) ff_q <= '0;
                else         ff_q <= {ff_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = ff_q[STAGES-1];

endmodule

// File: rtl/dgl_window.sv
module dgl_window #(
    parameter int DEPTH = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             d_i,
    output logic [DEPTH-1:0] taps_o,
    output logic             all_high_o,
    output logic             all_low_o
);

    logic [DEPTH-1:0] tap_q;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            logic stage_d;
            if (i == 0) begin : g_head
                assign stage_d = d_i;
            end else begin : g_tail
                assign stage_d = tap_q[i-1];
            end
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) tap_q[i] <= 1'b0;
                else         tap_q[i] <= stage_d;
            end
        end
    endgenerate

    assign taps_o     = tap_q;
    assign all_high_o = &tap_q;
    assign all_low_o  = ~|tap_q;

endmodule

// File: rtl/dgl_fsm.sv
module dgl_fsm
    import dgl_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic all_high_i,
    input  logic all_low_i,
    output logic level_o
);

    dgl_state_e state_q, state_d;

    // Next-state decision: T_RISE, T_FALL or T_HOLD.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOW:  state_d = all_high_i ? ST_HIGH : ST_LOW;
            ST_HIGH: state_d = all_low_i  ? ST_LOW  : ST_HIGH;
            default: state_d = ST_LOW;
        endcase
    end

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_LOW;
        else         state_q <= state_d;
    end

    // Output decode straight from the state flop.
    always_comb begin
        unique case (state_q)
            ST_HIGH: level_o = 1'b1;
            default: level_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/dgl_top.sv
module dgl_top #(
    parameter int SYNC_STAGES = 2,
    parameter int WINDOW      = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    input  logic clk_ok_i,
    output logic level_o,
    output logic filter_inactive_o
);

    localparam int LATENCY = SYNC_STAGES + WINDOW + 1;

    logic              sync_q;
    logic [WINDOW-1:0] win_taps;
    logic              win_high;
    logic              win_low;

    dgl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (pin_i),
        .q_o    (sync_q)
    );

    dgl_window #(.DEPTH(WINDOW)) u_window (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .d_i        (sync_q),
        .taps_o     (win_taps),
        .all_high_o (win_high),
        .all_low_o  (win_low)
    );

    dgl_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .all_high_i (win_high),
        .all_low_i  (win_low),
        .level_o    (level_o)
    );

    assign filter_inactive_o = ~clk_ok_i;

    initial begin
        if (LATENCY < 3) $display("dgl_top: unexpected latency %0d", LATENCY);
    end

endmodule

// File: rtl/dgl_checker.sv
module dgl_checker #(
    parameter int WINDOW = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              level_o,
    input logic [WINDOW-1:0] taps
);

    always @(posedge clk_i) begin
        if (!rst_ni) begin
            AST_RESET_LOW: assert (level_o == 1'b0); // R1
        end
    end

    AST_NO_SHORT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(level_o) |-> $past(&taps)); // R2

    AST_NO_SHORT_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(level_o) |-> $past(taps == '0)); // R3

    AST_RISE_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((&taps) && !level_o) |=> level_o); // R4

    AST_FALL_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((taps == '0) && level_o) |=> !level_o); // R4

    AST_MIXED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!(&taps) && (taps != '0)) |=> $stable(level_o)); // R5

endmodule

bind dgl_top dgl_checker #(.WINDOW(WINDOW)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_o (level_o),
    .taps    (win_taps)
);

// File: tb/dgl_top_tb.sv
`timescale 1ns/1ps
module dgl_top_tb_top;

    localparam int SYNC = 2;
    localparam int WIN  = 4;
    localparam int HMAX = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b1;
    logic pin = 1'b0;
    logic clk_ok = 1'b1;
    logic level;
    logic inactive;

    always #2 clk = ~clk;

    dgl_top #(.SYNC_STAGES(SYNC), .WINDOW(WIN)) dut_i (
        .clk_i             (clk),
        .rst_ni            (rst_n),
        .pin_i             (pin),
        .clk_ok_i          (clk_ok),
        .level_o           (level),
        .filter_inactive_o (inactive)
    );

    int    vectors = 0;
    int    miscompares = 0;
    bit    hist [HMAX];
    int    edge_n = 0;
    bit    model_lvl = 1'b0;
    bit    exp_q [$];
    string tag_q [$];
    string cur_tag = "R1";
    bit    run_monitor = 1'b0;

    function automatic bit sample_at(int idx);
        if (idx < 0) return 1'b0;
        return hist[idx];
    endfunction

    task automatic check(string tag, bit act, bit exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: applies one sample and queues the level expected after that edge.
    task automatic step(bit v);
        int ones;
        @(negedge clk);
        pin = v;
        hist[edge_n] = v;
        ones = 0;
        for (int j = SYNC + WIN; j > SYNC; j--) ones += sample_at(edge_n - j);
        if (ones == WIN) model_lvl = 1'b1;
        else if (ones == 0) model_lvl = 1'b0;
        exp_q.push_back(model_lvl);
        tag_q.push_back(cur_tag);
        edge_n++;
    endtask

    task automatic hold(bit v, int n);
        for (int i = 0; i < n; i++) step(v);
    endtask

    // Monitor: pops one expected item per edge, shortly after the edge.
    always @(posedge clk) begin
        #1;
        if (run_monitor && exp_q.size() > 0) begin
            bit    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, level, e);
        end
    end

    initial begin
        #400000;
        miscompares++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 check("R1", level, 1'b0);
        check("R6", inactive, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        run_monitor = 1'b1;

        cur_tag = "R1"; hold(1'b0, 10);
        cur_tag = "R2";
        hold(1'b1, 1); hold(1'b0, 9);
        hold(1'b1, 2); hold(1'b0, 9);
        hold(1'b1, 3); hold(1'b0, 10);
        cur_tag = "R4"; hold(1'b1, 4); hold(1'b0, 12);
        hold(1'b1, 14);
        cur_tag = "R3";
        hold(1'b0, 1); hold(1'b1, 9);
        hold(1'b0, 2); hold(1'b1, 9);
        hold(1'b0, 3); hold(1'b1, 10);
        cur_tag = "R4"; hold(1'b0, 14);
        cur_tag = "R5";
        for (int i = 0; i < 6; i++) begin step(1'b1); step(1'b0); end
        hold(1'b1, 12);
        for (int i = 0; i < 6; i++) begin step(1'b0); step(1'b1); end
        step(1'b1); step(1'b1); step(1'b0); step(1'b1); step(1'b1);
        hold(1'b1, 10);

        cur_tag = "R6";
        @(negedge clk); clk_ok = 1'b0;
        #1 check("R6", inactive, 1'b1);
        hold(1'b1, 3);
        #1 check("R6", level, 1'b1);
        @(negedge clk); clk_ok = 1'b1;
        #1 check("R6", inactive, 1'b0);
        hold(1'b1, 8);
        while (exp_q.size() > 0) @(negedge clk);

        @(negedge clk); #0.5;
        rst_n = 1'b0;
        #0.2 check("R7", level, 1'b0);
        run_monitor = 1'b0;
        @(posedge clk); #1 check("R7", level, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule